// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two 16-bit timer/counters, unit 0 and unit 1. Each unit increments either on a per-cycle `tick` qualifier (timer use) or on falling transitions of its own external count pin (counter use). Counting is enabled by a run bit and can also be qualified by the level of a gate pin. A 2-bit mode field per unit selects one of four counting structures:

- a 13-bit counter built from a 5-bit prescaler and an 8-bit upper byte;
- a plain 16-bit counter;
- an 8-bit counter that reloads itself from a holding byte;
- a split arrangement in which unit 0 becomes two independent 8-bit timers.

Each unit owns one overflow flag. Hardware sets the flag. Software can overwrite it through the write port, and an acknowledge pulse clears it.

Software programs the block through a simple register write port. Every write is accepted in the cycle it is presented; there is no back-pressure and no ready signal. The count values and the two overflow flags are plain outputs. The gate pins are used as synchronous levels. The count pins pass through a synchronizer before edge detection.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset both counts are 0x0000, both flags are 0, and the run, gate, select and mode settings are all 0. Neither unit counts until a run bit is written.
- R2: The write port decodes these addresses:
  - 0: configuration byte. Bits [1:0] are the unit 0 mode, bit 2 is the unit 0 select (1 = external pin), bit 3 is the unit 0 gate. Bits [5:4], 6 and 7 are the same fields for unit 1.
  - 1: run bits (bit 0 = unit 0, bit 1 = unit 1).
  - 2 and 3: unit 0 low and high count bytes.
  - 4 and 5: unit 1 low and high count bytes.
  - 6: flag bits (bit 0 = unit 0, bit 1 = unit 1).

  A count write appears on the count outputs after the next clock edge.
- R3: With select = 0, a running unit advances once per cycle in which `tick` is high. It holds when `tick` is low or its run bit is 0.
- R4: With gate = 1, a running unit counts only while its gate pin is high. With gate = 0, the gate pin has no effect.
- R5: With select = 1, a unit counts one event for each 1-to-0 transition of its count pin, after sampling. It ignores `tick`.
- R6: Mode 01 counts over 16 bits. Stepping from 0xFFFF wraps to 0x0000 and sets the unit's flag.
- R7: Mode 00 counts over 13 bits: bits [4:0] of the low byte carry into the high byte. Bits [7:5] of the low byte are left unchanged. Stepping from high 0xFF with low[4:0] 0x1F clears both fields and sets the flag.
- R8: Mode 10 counts the low byte only. When the low byte steps from 0xFF, it is loaded from the unchanged high byte and the flag is set on every such reload.
- R9: When unit 0 is in mode 11, its low byte is an 8-bit counter that uses unit 0's select, gate and run bits and sets flag 0. Its high byte counts `tick` while unit 1's run bit is 1 and sets flag 1 on wrap.
- R10: While unit 0 is in mode 11, unit 1 counts regardless of its run bit and never sets flag 1. A unit 1 that is itself in mode 11 holds its count.
- R11: An acknowledge pulse clears a flag, and a write to address 6 loads both flags. A hardware set in the same cycle takes priority over either.
- R12: A count byte write in the same cycle as an increment takes priority for that byte. The count then continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Per-cycle count qualifier for timer use |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| ext_cnt | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | Gate level pins, one per unit |
| ack | input | 2 | Flag acknowledge pulses, one per unit |
| ovf_flag | output | 2 | Overflow flags, one per unit |
| count0 | output | 16 | Unit 0 count as {high, low} |
| count1 | output | 16 | Unit 1 count as {high, low} |

## Verification
The bench builds the block with its defaults:
- 8-bit count bytes;
- a 5-bit prescaler field for the 13-bit mode;
- a two-stage pin synchronizer.

With 8-bit bytes, every wrap and reload point can be reached in a handful of cycles by preloading values near all-ones. This makes each overflow, the reload sequence and the split-mode overflows exactly predictable. The 5-bit prescaler lets a single step show both the carry into the high byte and the untouched upper low bits. The two-stage synchronizer keeps the external count latency short enough for pulse trains of a few cycles to be counted exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_13    = 2'd0,
    TM_16    = 2'd1,
    TM_RLD   = 2'd2,
    TM_SPLIT = 2'd3
  } tmr_mode_e;

  localparam int UNITS  = 2;
  localparam int A_CFG  = 0;
  localparam int A_RUN  = 1;
  localparam int A_LO0  = 2;
  localparam int A_HI0  = 3;
  localparam int A_FLAG = 6;

endpackage

// File: rtl/tmr_evsync.sv
module tmr_evsync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] shf;
    logic              prev;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shf  <= '0;
        prev <= 1'b0;
      end else begin
        shf  <= {shf[STAGES-2:0], pin[i]};
        prev <= shf[STAGES-1];
      end
    end

    assign fall[i] = prev & ~shf[STAGES-1];

    // R5
    fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !prev);
  end

endmodule

// File: rtl/tmr_cfg.sv
module tmr_cfg
  import tmr_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [W-1:0]          wr_data,
  output logic [UNITS-1:0][1:0] mode,
  output logic [UNITS-1:0]      ctsel,
  output logic [UNITS-1:0]      gate,
  output logic [UNITS-1:0]      run,
  output logic [UNITS-1:0]      wr_lo,
  output logic [UNITS-1:0]      wr_hi,
  output logic                  flag_wr,
  output logic [UNITS-1:0]      flag_wdata
);

  logic [W-1:0]     cfg_q;
  logic [UNITS-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CFG)) cfg_q <= wr_data;
      if (wr_addr == ADDR_W'(A_RUN)) run_q <= wr_data[UNITS-1:0];
    end
  end

  for (genvar i = 0; i < UNITS; i++) begin : g_dec
    assign mode[i]  = cfg_q[4*i +: 2];
    assign ctsel[i] = cfg_q[4*i+2];
    assign gate[i]  = cfg_q[4*i+3];
    assign run[i]   = run_q[i];
    assign wr_lo[i] = wr_en && (wr_addr == ADDR_W'(A_LO0 + 2*i));
    assign wr_hi[i] = wr_en && (wr_addr == ADDR_W'(A_HI0 + 2*i));
  end

  assign flag_wr    = wr_en && (wr_addr == ADDR_W'(A_FLAG));
  assign flag_wdata = wr_data[UNITS-1:0];

  // R1
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(run));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE   = 5,
  parameter bit SPLIT = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_e mode,
  input  logic      inc_lo,
  input  logic      inc_hi,
  input  logic      wr_lo,
  input  logic      wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic      ovf_main,
  output logic      ovf_hi
);

  logic [W-1:0] nxt_lo, nxt_hi;
  logic         raw_m, raw_h;

  always_comb begin
    nxt_lo = lo;
    nxt_hi = hi;
    raw_m  = 1'b0;
    raw_h  = 1'b0;
    unique case (mode)
      TM_13: begin
        if (inc_lo) begin
          if (&lo[PRE-1:0]) begin
            nxt_lo[PRE-1:0] = '0;
            if (&hi) begin
              nxt_hi = '0;
              raw_m  = 1'b1;
            end else begin
              nxt_hi = hi + 1'b1;
            end
          end else begin
            nxt_lo[PRE-1:0] = lo[PRE-1:0] + 1'b1;
          end
        end
      end
      TM_16: begin
        if (inc_lo) begin
          {nxt_hi, nxt_lo} = {hi, lo} + 1'b1;
          raw_m = &{hi, lo};
        end
      end
      TM_RLD: begin
        if (inc_lo) begin
          if (&lo) begin
            nxt_lo = hi;
            raw_m  = 1'b1;
          end else begin
            nxt_lo = lo + 1'b1;
          end
        end
      end
      TM_SPLIT: begin
        if (SPLIT) begin
          if (inc_lo) begin
            nxt_lo = lo + 1'b1;
            raw_m  = &lo;
          end
          if (inc_hi) begin
            nxt_hi = hi + 1'b1;
            raw_h  = &hi;
          end
        end
      end
    endcase
    if (wr_lo) nxt_lo = wdata;
    if (wr_hi) nxt_hi = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= nxt_lo;
      hi <= nxt_hi;
    end
  end

  assign ovf_main = raw_m & ~(wr_lo | wr_hi);
  assign ovf_hi   = raw_h & ~wr_hi;

  // R6
  step16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_16 && inc_lo && !wr_lo && !wr_hi)
      |=> {hi, lo} == (2*W)'($past({hi, lo}) + 1'b1));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_RLD && inc_lo && (&lo) && !wr_lo && !wr_hi)
      |=> (lo == $past(hi)) && $stable(hi));

  // R7
  top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_13 && !wr_lo) |=> lo[W-1:PRE] == $past(lo[W-1:PRE]));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_lo && !inc_hi && !wr_lo && !wr_hi) |=> $stable(lo) && $stable(hi));

  // R12
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo == $past(wdata));

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] ack,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)       flag[i] <= 1'b0;
      else if (set[i])  flag[i] <= 1'b1;
      else if (ack[i])  flag[i] <= 1'b0;
      else if (wr)      flag[i] <= wdata[i];
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);

    // R11
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !set[i]) |=> !flag[i]);
  end

endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int W      = 8,
  parameter int PRE    = 5,
  parameter int SYNC   = 2,
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [1:0]      ext_cnt,
  input  logic [1:0]      gate_pin,
  input  logic [1:0]      ack,
  output logic [1:0]      ovf_flag,
  output logic [2*W-1:0]  count0,
  output logic [2*W-1:0]  count1
);

  logic [UNITS-1:0][1:0] mode;
  logic [UNITS-1:0]      ctsel, gate, run, wr_lo, wr_hi, flag_wdata;
  logic                  flag_wr;
  logic [UNITS-1:0]      fall, run_eff, ev, inc_lo, inc_hi;
  logic [UNITS-1:0]      ovf_m, ovf_h, set;
  logic [UNITS-1:0][W-1:0] lo, hi;
  logic                  split;

  tmr_cfg #(.W(W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode(mode), .ctsel(ctsel), .gate(gate),
    .run(run), .wr_lo(wr_lo), .wr_hi(wr_hi), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata)
  );

  tmr_evsync #(.N(UNITS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_cnt), .fall(fall)
  );

  assign split      = (mode[0] == 2'(TM_SPLIT));
  assign run_eff[0] = run[0];
  assign run_eff[1] = run[1] | split;
  assign inc_hi[0]  = split & run[1] & tick;
  assign inc_hi[1]  = 1'b0;

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    assign ev[i]     = ctsel[i] ? fall[i] : tick;
    assign inc_lo[i] = run_eff[i] & (~gate[i] | gate_pin[i]) & ev[i];

    tmr_unit #(.W(W), .PRE(PRE), .SPLIT(i == 0)) u_unit (
      .clk(clk), .rst_n(rst_n), .mode(tmr_mode_e'(mode[i])),
      .inc_lo(inc_lo[i]), .inc_hi(inc_hi[i]), .wr_lo(wr_lo[i]),
      .wr_hi(wr_hi[i]), .wdata(wr_data), .lo(lo[i]), .hi(hi[i]),
      .ovf_main(ovf_m[i]), .ovf_hi(ovf_h[i])
    );
  end

  assign set[0] = ovf_m[0];
  assign set[1] = split ? ovf_h[0] : ovf_m[1];

  tmr_flags #(.N(UNITS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set), .ack(ack), .wr(flag_wr),
    .wdata(flag_wdata), .flag(ovf_flag)
  );

  assign count0 = {hi[0], lo[0]};
  assign count1 = {hi[1], lo[1]};

  // R10
  split_flag1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !ovf_h[0] && !flag_wr && !ovf_flag[1]) |=> !ovf_flag[1]);

  // R4
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate[0] && !gate_pin[0] && !wr_lo[0] && !wr_hi[0] && !split)
      |=> $stable(count0));

endmodule

// File: tb/tb_tmr_pair_top.sv
module tb_tmr_pair_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  ext_cnt = '0;
  logic [1:0]  gate_pin = '0;
  logic [1:0]  ack = '0;
  logic [1:0]  ovf_flag;
  logic [15:0] count0, count1;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_pair_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_cnt(ext_cnt),
    .gate_pin(gate_pin), .ack(ack), .ovf_flag(ovf_flag),
    .count0(count0), .count1(count1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_for(input logic [1:0] mask, input int n);
    wr(3'd1, {6'd0, mask});
    repeat (n - 1) @(negedge clk);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 count0", count0, 16'h0000);
    chk("R1 count1", count1, 16'h0000);
    chk("R1 flags", ovf_flag, 2'b00);
    repeat (6) @(negedge clk);
    chk("R1 idle after reset", {count1, count0}, 32'h0);
  endtask

  task automatic t_load;
    wr(3'd0, 8'h11);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    chk("R2 unit0 bytes", count0, 16'hFFFE);
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    chk("R2 unit1 bytes", count1, 16'h1234);
  endtask

  task automatic t_mode16;
    wr(3'd6, 8'h00);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    run_for(2'b01, 3);
    chk("R6 wrap value", count0, 16'h0001);
    chk("R6 flag", ovf_flag, 2'b01);
  endtask

  task automatic t_tick;
    wr(3'd0, 8'h11);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    tick = 1'b0;
    wr(3'd1, 8'h01);
    repeat (8) @(negedge clk);
    wr(3'd1, 8'h00);
    chk("R3 tick low holds", count0, 16'h0000);
    tick = 1'b1;
    run_for(2'b01, 9);
    chk("R3 tick counts", count0, 16'h0009);
  endtask

  task automatic t_gate;
    wr(3'd0, 8'h19);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gate_pin = 2'b00;
    run_for(2'b01, 10);
    chk("R4 gate low blocks", count0, 16'h0000);
    gate_pin = 2'b01;
    run_for(2'b01, 7);
    chk("R4 gate high counts", count0, 16'h0007);
    gate_pin = 2'b00;
    wr(3'd0, 8'h11);
    wr(3'd2, 8'h00);
    run_for(2'b01, 4);
    chk("R4 gate off ignores pin", count0, 16'h0004);
  endtask

  task automatic t_ext;
    wr(3'd0, 8'h51);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h02);
    for (int k = 0; k < 5; k++) begin
      ext_cnt[1] = 1'b1;
      repeat (3) @(negedge clk);
      ext_cnt[1] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(3'd1, 8'h00);
    chk("R5 falling edges counted", count1, 16'h0005);
  endtask

  task automatic t_mode13;
    wr(3'd0, 8'h10);
    wr(3'd6, 8'h00);
    wr(3'd2, 8'hBF); wr(3'd3, 8'h10);
    run_for(2'b01, 1);
    chk("R7 carry into high", count0, 16'h11A0);
    chk("R7 no flag on carry", ovf_flag, 2'b00);
    wr(3'd2, 8'hFD); wr(3'd3, 8'hFF);
    run_for(2'b01, 3);
    chk("R7 13-bit wrap", count0, 16'h00E0);
    chk("R7 flag", ovf_flag, 2'b01);
  endtask

  task automatic t_reload;
    wr(3'd0, 8'h21);
    wr(3'd6, 8'h00);
    wr(3'd5, 8'hF0); wr(3'd4, 8'hFE);
    run_for(2'b10, 2);
    chk("R8 first reload", count1, 16'hF0F0);
    chk("R8 flag on reload", ovf_flag, 2'b10);
    wr(3'd6, 8'h00);
    run_for(2'b10, 20);
    chk("R8 second reload", count1, 16'hF0F4);
    chk("R8 flag again", ovf_flag, 2'b10);
  endtask

  task automatic t_split;
    logic [15:0] snap;
    wr(3'd0, 8'h13);
    wr(3'd6, 8'h00);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFD);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    run_for(2'b11, 3);
    chk("R9 split bytes", count0, 16'h0001);
    chk("R9 both flags", ovf_flag, 2'b11);
    wr(3'd6, 8'h00);
    wr(3'd4, 8'hF0); wr(3'd5, 8'hFF);
    repeat (40) @(negedge clk);
    chk("R10 unit1 free-runs", count1, 16'h0019);
    chk("R10 flag1 quiet", ovf_flag, 2'b00);
    chk("R10 unit0 held", count0, 16'h0001);
    wr(3'd0, 8'h31);
    wr(3'd1, 8'h02);
    snap = count1;
    repeat (10) @(negedge clk);
    chk("R10 unit1 mode3 holds", count1, snap);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_flags;
    wr(3'd6, 8'h03);
    chk("R11 flag write", ovf_flag, 2'b11);
    ack = 2'b01;
    @(negedge clk);
    ack = 2'b00;
    chk("R11 ack clears", ovf_flag, 2'b10);
    wr(3'd6, 8'h00);
    chk("R11 write clears", ovf_flag, 2'b00);
    wr(3'd0, 8'h11);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd1, 8'h01);
    ack = 2'b01;
    wr(3'd1, 8'h00);
    ack = 2'b00;
    chk("R11 set beats ack", ovf_flag, 2'b01);
    chk("R11 wrapped", count0, 16'h0000);
  endtask

  task automatic t_race;
    wr(3'd0, 8'h11);
    wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h55);
    wr(3'd1, 8'h00);
    chk("R12 write wins then counts", count0, 16'h0056);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_mode16();
    t_tick();
    t_gate();
    t_ext();
    t_mode13();
    t_reload();
    t_split();
    t_flags();
    t_race();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule